// File: doc/BRIEF.md
# Paged White Balance Lookup

This block corrects the colour balance of a 24-bit RGB pixel stream. Each subpixel indexes its own 256-entry, 8-bit table, and the entry it reads replaces it. There is one table for red, one for green and one for blue. Software loads the tables through a byte-wide register port. A single control byte chooses which page appears in a 256-address register window: the configuration page or one of the three tables. The same byte holds the enable and reload controls.

Register writes land in a shadow set of tables. The tables that the pixel path uses are a separate active set. The shadow set is copied into the active set in one cycle, at a frame-start pulse, and only while reload is enabled. A frame therefore never shows a mix of old and new entries.

The pixel path always has one cycle of latency, whether correction is on or off. Valid, hsync and vsync travel with the data.

Register addresses are 9 bits wide:
- Bit 8 = 0 selects the fixed space. The control byte sits at 0x02A there on every page.
- Bit 8 = 1 selects the paged window. Its low 8 bits address the selected page.

Top module: `pixel_wb_lut`

## Requirements
- R1: After synchronous reset, the control byte reads 0x00, out_vld is 0 and reg_rdata is 0.
- R2: Control byte layout:
  - bits 7:6 are the page (00 configuration, 01 red, 10 green, 11 blue);
  - bit 5 enables correction;
  - bit 4 enables reload;
  - bits 3:0 ignore writes and read back as 0.
- R3: With the page at 01, 10 or 11, window address 0x100+i writes shadow entry i of the red, green or blue table. Reading that address returns the entry.
- R4: Read data is registered, so it appears one cycle after the address. The control byte reads at fixed address 0x02A on any page. With page 00 it also reads at window address 0x12A. Every other fixed or configuration address reads 0 and ignores writes.
- R5: With correction enabled, each output subpixel equals the active entry of its own table at the input subpixel's value, one cycle after the input.
- R6: With correction disabled, the output equals the input one cycle later.
- R7: Writes to the shadow tables do not change the output until a frame_start pulse arrives while reload is 1. A pulse with reload 0 changes nothing. The pixel sampled in the same cycle as the copying pulse still uses the old entries.
- R8: out_vld, out_hs and out_vs equal pix_vld, pix_hs and pix_vs delayed by one cycle.
- R9: The page setting has no effect on the pixel output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Bit 8 selects window, bits 7:0 offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| pix_vld | input | 1 | Input pixel valid |
| pix_hs | input | 1 | Input hsync |
| pix_vs | input | 1 | Input vsync |
| pix_r | input | 8 | Input red |
| pix_g | input | 8 | Input green |
| pix_b | input | 8 | Input blue |
| out_vld | output | 1 | Output pixel valid |
| out_hs | output | 1 | Output hsync |
| out_vs | output | 1 | Output vsync |
| out_r | output | 8 | Corrected red |
| out_g | output | 8 | Corrected green |
| out_b | output | 8 | Corrected blue |

## Verification
The hardest case to reach is a shadow table that holds different values from the active one. Reaching it needs a full table load, then a reload, then a rewrite of one table.

The bench loads all three tables with distinct arithmetic patterns and sweeps every index through the pixel path. It then rewrites the red table and probes the output at each step:
- with reload off;
- after a frame pulse with reload off;
- with reload on but no pulse yet;
- after the copying pulse.

The new values must appear only at the last step.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    PG_CFG = 2'b00,
    PG_RED = 2'b01,
    PG_GRN = 2'b10,
    PG_BLU = 2'b11
  } page_e;

  typedef struct packed {
    page_e page;
    logic  en;
    logic  reload;
  } ctrl_t;

  localparam int NUM_CH = 3;

  function automatic logic [7:0] ctrl_byte(ctrl_t c);
    return {c.page, c.en, c.reload, 4'b0000};
  endfunction
endpackage

// File: rtl/wb_ctrl.sv
module wb_ctrl
  import wb_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter logic [ADDR_W-2:0] CTRL_ADDR = 'h2A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output ctrl_t             ctrl
);
  logic hit;

  always_comb begin
    hit = we && (addr[ADDR_W-2:0] == CTRL_ADDR) &&
          (!addr[ADDR_W-1] || ctrl.page == PG_CFG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (hit) begin
      ctrl.page   <= page_e'(wdata[7:6]);
      ctrl.en     <= wdata[5];
      ctrl.reload <= wdata[4];
    end
  end
endmodule

// File: rtl/wb_lut_chan.sv
module wb_lut_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  input  logic [DATA_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] pix_idx,
  output logic [DATA_W-1:0] pix_val
);
  localparam int DEPTH = 1 << DATA_W;

  logic [DATA_W-1:0] shadow [DEPTH];
  logic [DATA_W-1:0] active [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) shadow[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (load) active <= shadow;
  end

  assign rd_data = shadow[rd_idx];
  assign pix_val = active[pix_idx];
endmodule

// File: rtl/pixel_wb_lut.sv
module pixel_wb_lut
  import wb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = DATA_W + 1,
  parameter logic [DATA_W-1:0] CTRL_ADDR = 'h2A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              frame_start,
  input  logic              pix_vld,
  input  logic              pix_hs,
  input  logic              pix_vs,
  input  logic [DATA_W-1:0] pix_r,
  input  logic [DATA_W-1:0] pix_g,
  input  logic [DATA_W-1:0] pix_b,
  output logic              out_vld,
  output logic              out_hs,
  output logic              out_vs,
  output logic [DATA_W-1:0] out_r,
  output logic [DATA_W-1:0] out_g,
  output logic [DATA_W-1:0] out_b
);
  ctrl_t             ctrl;
  logic              in_win;
  logic              load;
  logic [DATA_W-1:0] pix_in  [NUM_CH];
  logic [DATA_W-1:0] pix_lut [NUM_CH];
  logic [DATA_W-1:0] rd_ch   [NUM_CH];
  logic [DATA_W-1:0] pix_sel [NUM_CH];
  logic [7:0]        rd_next;

  assign in_win = reg_addr[ADDR_W-1];
  assign load   = frame_start && ctrl.reload;
  assign pix_in[0] = pix_r;
  assign pix_in[1] = pix_g;
  assign pix_in[2] = pix_b;

  wb_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .ctrl(ctrl)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic wr_k;
    assign wr_k = reg_we && in_win && (ctrl.page == page_e'(k + 1));
    wb_lut_chan #(.DATA_W(DATA_W)) u_chan (
      .clk(clk),
      .wr_en(wr_k),
      .wr_idx(reg_addr[DATA_W-1:0]),
      .wr_data(reg_wdata[DATA_W-1:0]),
      .load(load),
      .rd_idx(reg_addr[DATA_W-1:0]),
      .rd_data(rd_ch[k]),
      .pix_idx(pix_in[k]),
      .pix_val(pix_lut[k])
    );
    assign pix_sel[k] = ctrl.en ? pix_lut[k] : pix_in[k];
  end

  always_comb begin
    rd_next = '0;
    if (!in_win || ctrl.page == PG_CFG) begin
      if (reg_addr[DATA_W-1:0] == CTRL_ADDR) rd_next = ctrl_byte(ctrl);
    end else begin
      rd_next = 8'(rd_ch[ctrl.page - 2'd1]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_hs  <= 1'b0;
      out_vs  <= 1'b0;
      out_r   <= '0;
      out_g   <= '0;
      out_b   <= '0;
    end else begin
      out_vld <= pix_vld;
      out_hs  <= pix_hs;
      out_vs  <= pix_vs;
      out_r   <= pix_sel[0];
      out_g   <= pix_sel[1];
      out_b   <= pix_sel[2];
    end
  end
endmodule

// File: rtl/wb_checker.sv
module wb_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 9,
  parameter logic [DATA_W-1:0] CTRL_ADDR = 'h2A
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_rdata,
  input logic              wb_en,
  input logic              pix_vld,
  input logic              pix_hs,
  input logic              pix_vs,
  input logic [DATA_W-1:0] pix_r,
  input logic [DATA_W-1:0] pix_g,
  input logic [DATA_W-1:0] pix_b,
  input logic              out_vld,
  input logic              out_hs,
  input logic              out_vs,
  input logic [DATA_W-1:0] out_r,
  input logic [DATA_W-1:0] out_g,
  input logic [DATA_W-1:0] out_b
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_vld && reg_rdata == 8'h00));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == {1'b0, CTRL_ADDR}) |=> (reg_rdata[3:0] == 4'h0));

  a_r6_bypass: assert property (@(posedge clk) disable iff (rst)
    !wb_en |=> (out_r == $past(pix_r) && out_g == $past(pix_g) &&
                out_b == $past(pix_b)));

  a_r8_sync_delay: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_vld == $past(pix_vld) && out_hs == $past(pix_hs) &&
              out_vs == $past(pix_vs)));
endmodule

bind pixel_wb_lut wb_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .wb_en(ctrl.en),
  .pix_vld(pix_vld), .pix_hs(pix_hs), .pix_vs(pix_vs),
  .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
  .out_vld(out_vld), .out_hs(out_hs), .out_vs(out_vs),
  .out_r(out_r), .out_g(out_g), .out_b(out_b)
);

// File: tb/pixel_wb_lut_bench.sv
module pixel_wb_lut_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0;
  logic [8:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       frame_start = 1'b0;
  logic       pix_vld = 1'b0, pix_hs = 1'b0, pix_vs = 1'b0;
  logic [7:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic       out_vld, out_hs, out_vs;
  logic [7:0] out_r, out_g, out_b;
  int         n_cmp = 0;
  int         n_bad = 0;

  always #5 clk = ~clk;

  pixel_wb_lut u_pixel_wb_lut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .pix_vld(pix_vld), .pix_hs(pix_hs), .pix_vs(pix_vs),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .out_vld(out_vld), .out_hs(out_hs), .out_vs(out_vs),
    .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  function automatic logic [7:0] tbl(int ch, int i);
    case (ch)
      1: return 8'((i * 7 + 3) & 255);
      2: return 8'(255 - i);
      default: return 8'(i) ^ 8'h5A;
    endcase
  endfunction

  function automatic logic [7:0] cbyte(logic [1:0] pg, logic en, logic rl);
    return {pg, en, rl, 4'b0000};
  endfunction

  task automatic cmp(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk); #1;
    cmp(req, {24'h0, reg_rdata}, {24'h0, exp});
  endtask

  task automatic fpulse();
    @(negedge clk);
    frame_start = 1'b1;
    @(posedge clk); #1;
    frame_start = 1'b0;
  endtask

  task automatic px(logic [7:0] r, logic [7:0] g, logic [7:0] b,
                    logic [2:0] syn, logic [7:0] er, logic [7:0] eg,
                    logic [7:0] eb, string req);
    @(negedge clk);
    pix_r = r; pix_g = g; pix_b = b;
    {pix_vld, pix_hs, pix_vs} = syn;
    @(posedge clk); #1;
    cmp(req, {8'h0, out_r, out_g, out_b}, {8'h0, er, eg, eb});
    cmp("R8", {29'h0, out_vld, out_hs, out_vs}, {29'h0, syn});
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cmp("R1", {31'h0, out_vld}, 32'h0);
    cmp("R1", {24'h0, reg_rdata}, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    rd(9'h02A, 8'h00, "R1");

    // R2: reserved bits written as ones read back zero
    wr(9'h02A, cbyte(2'b01, 1'b0, 1'b0) | 8'h0F);
    rd(9'h02A, 8'h40, "R2");
    wr(9'h02A, 8'h3F);
    rd(9'h02A, 8'h30, "R2");

    // R3: load and read back every entry of every table
    for (int ch = 1; ch <= 3; ch++) begin
      wr(9'h02A, cbyte(2'(ch), 1'b0, 1'b0));
      for (int i = 0; i < 256; i++) wr(9'h100 | 9'(i), tbl(ch, i));
    end
    for (int ch = 1; ch <= 3; ch++) begin
      wr(9'h02A, cbyte(2'(ch), 1'b0, 1'b0));
      for (int i = 0; i < 256; i++) rd(9'h100 | 9'(i), tbl(ch, i), "R3");
      rd(9'h02A, cbyte(2'(ch), 1'b0, 1'b0), "R4");
      rd(9'h010, 8'h00, "R4");
    end

    // R4: configuration page view
    wr(9'h02A, cbyte(2'b00, 1'b0, 1'b0));
    wr(9'h105, 8'hEE);
    rd(9'h105, 8'h00, "R4");
    rd(9'h12A, 8'h00, "R4");
    wr(9'h12A, cbyte(2'b00, 1'b0, 1'b1));
    rd(9'h12A, 8'h10, "R4");
    rd(9'h02A, 8'h10, "R4");

    // R6: bypass sweep
    wr(9'h02A, cbyte(2'b00, 1'b0, 1'b0));
    for (int i = 0; i < 256; i++)
      px(8'(i), 8'(255 - i), 8'(i * 3), 3'(i), 8'(i), 8'(255 - i), 8'(i * 3), "R6");

    // R5: load tables into active set, enabled sweep
    wr(9'h02A, cbyte(2'b00, 1'b1, 1'b1));
    fpulse();
    for (int i = 0; i < 256; i++)
      px(8'(i), 8'(255 - i), 8'(i * 3), 3'b100,
         tbl(1, i), tbl(2, 255 - i), tbl(3, (i * 3) & 255), "R5");

    // R7: shadow rewrite of red table
    wr(9'h02A, cbyte(2'b01, 1'b1, 1'b0));
    for (int i = 0; i < 256; i++) wr(9'h100 | 9'(i), 8'(i + 1));
    for (int i = 0; i < 256; i += 17)
      px(8'(i), 8'(i), 8'(i), 3'b110, tbl(1, i), tbl(2, i), tbl(3, i), "R7");
    fpulse();
    for (int i = 0; i < 256; i += 17)
      px(8'(i), 8'(i), 8'(i), 3'b101, tbl(1, i), tbl(2, i), tbl(3, i), "R7");
    wr(9'h02A, cbyte(2'b01, 1'b1, 1'b1));
    px(8'd9, 8'd9, 8'd9, 3'b100, tbl(1, 9), tbl(2, 9), tbl(3, 9), "R7");
    // pixel in the same cycle as the copying pulse uses old entries
    @(negedge clk);
    frame_start = 1'b1;
    pix_r = 8'd20; pix_g = 8'd20; pix_b = 8'd20;
    {pix_vld, pix_hs, pix_vs} = 3'b100;
    @(posedge clk); #1;
    frame_start = 1'b0;
    cmp("R7", {8'h0, out_r, out_g, out_b}, {8'h0, tbl(1, 20), tbl(2, 20), tbl(3, 20)});
    for (int i = 0; i < 256; i++)
      px(8'(i), 8'(i), 8'(i), 3'b100, 8'(i + 1), tbl(2, i), tbl(3, i), "R7");

    // R9: page setting does not affect pixels
    for (int pg = 0; pg < 4; pg++) begin
      wr(9'h02A, cbyte(2'(pg), 1'b1, 1'b0));
      for (int i = 0; i < 256; i += 51)
        px(8'(i), 8'(i), 8'(i), 3'b111, 8'(i + 1), tbl(2, i), tbl(3, i), "R9");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule